// File: doc/BRIEF.md
# Legacy Interrupt Event Queue Register Block

This block sits beside a PCIe root port and collects legacy INTx assert and deassert messages arriving from downstream. Each message carries a lane number (0 to 3) and a level. The block stores it in a small circular queue. It drives a single level-sensitive interrupt line toward the host whenever an unmasked pending bit is set in its decode register. The block also folds an MSI-received pulse into that decode register.

Software reaches the block through a synchronous register port with word addresses and 32-bit data. Reads are combinational and have no side effect. Software reads the head of the queue from one of two queue words. Writing either queue word removes the head. While the queue still holds entries, the INTx pending bit in the decode register cannot be cleared. If an event arrives when the queue is full, the event is dropped and a sticky overflow flag is raised. The status register also carries a bridge-enable control bit and a queue-not-empty flag. A read-only PHY word reports link-up.

Top module: `intx_queue_regs`

## Requirements
- R1: After reset, the decode, mask and status registers read 0, the queue is empty, `irqOut` is 0 and `bridgeEn` is 0.
- R2: `irqOut` is 1 exactly when the bitwise AND of the decode register (word 0x4E) and the mask register (word 0x4F) is nonzero. It follows a decode write, a mask write, an MSI pulse or a queue push on the next cycle.
- R3: Writing the decode register clears every bit written as 1. Bit 16 (INTx pending) is set by every accepted push, and it stays set while the queue holds at least one entry.
- R4: Queue word 1 (word 0x56) returns the head entry as follows: bit 31 = 1, bit 30 = 0, bit 29 = level (1 assert, 0 deassert), bits 28:27 = lane, all other bits 0. Queue word 2 (word 0x57) returns 0.
- R5: With DEPTH slots the queue holds DEPTH-1 entries. A push into a full queue with no pop in the same cycle is discarded and sets status bit 19 (overflow).
- R6: Overflow is sticky. Writing the status register (word 0x52) with bit 19 = 1 clears it, and writing bit 19 = 0 leaves it unchanged.
- R7: Reading either queue word on an empty queue returns 0. Reads never change the queue.
- R8: A write of any value to word 0x56 or word 0x57 removes the head entry. Such a write on an empty queue is ignored.
- R9: A push and a pop in the same cycle both take effect. When the queue is full, the pop frees a slot first, so the push is stored and no overflow is flagged.
- R10: Status bit 0 is a read/write bridge-enable bit, driven on `bridgeEn`. Status bit 18 reads 1 while the queue is not empty.
- R11: The PHY word (word 0x51) reads `linkUp` in bit 11 and 0 elsewhere. Writes to it have no effect.
- R12: A one-cycle `msiRecv` pulse sets decode bit 17.
- R13: The mask register is a full 32-bit read/write register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | ADDR_W | Register word address |
| regWrData | input | 32 | Register write data |
| regRdData | output | 32 | Combinational read data for regAddr |
| evtValid | input | 1 | INTx event strobe |
| evtLane | input | 2 | INTx lane of the event |
| evtLevel | input | 1 | 1 = assert, 0 = deassert |
| linkUp | input | 1 | Link-up status |
| msiRecv | input | 1 | MSI-received pulse |
| irqOut | output | 1 | Level interrupt toward the host |
| bridgeEn | output | 1 | Bridge-enable control bit |

## Verification
A software pop of the head entry and a new downstream event can arrive in the same cycle. The bench provokes this by driving a queue-word write and `evtValid` on the same clock, once with the queue full and once with a single entry. It judges the result by the unchanged entry count, the absence of overflow and the order of entries drained afterwards. A decode-register clear can also land while entries remain queued. The bench checks that bit 16 survives that clear and only drops once the queue has been drained.

// File: rtl/intx_queue_pkg.sv
package intx_queue_pkg;
  // Register word addresses (byte offset / 4)
  localparam int OFS_DECODE = 'h4E;
  localparam int OFS_MASK   = 'h4F;
  localparam int OFS_PHY    = 'h51;
  localparam int OFS_STATUS = 'h52;
  localparam int OFS_QWORD1 = 'h56;
  localparam int OFS_QWORD2 = 'h57;

  // Bit positions
  localparam int BIT_INTX     = 16;
  localparam int BIT_MSI      = 17;
  localparam int BIT_LINK     = 11;
  localparam int BIT_BRIDGE   = 0;
  localparam int BIT_NONEMPTY = 18;
  localparam int BIT_OVERFLOW = 19;

  typedef enum logic [2:0] {
    RD_NONE, RD_DECODE, RD_MASK, RD_PHY, RD_STATUS, RD_QWORD1, RD_QWORD2
  } rd_sel_t;

  typedef struct packed {
    logic    wrDecode;
    logic    wrMask;
    logic    wrStatus;
    logic    popReq;
    logic    pushReq;
    rd_sel_t rdSel;
  } ctrl_strobes_t;
endpackage

// File: rtl/intx_queue_ctrl.sv
module intx_queue_ctrl
  import intx_queue_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              evtValid,
  output ctrl_strobes_t     strobes
);
  always_comb begin
    strobes = '0;
    strobes.rdSel = RD_NONE;
    strobes.pushReq = evtValid;
    if (regAddr == ADDR_W'(OFS_DECODE)) begin
      strobes.rdSel = RD_DECODE;
      strobes.wrDecode = regWrEn;
    end else if (regAddr == ADDR_W'(OFS_MASK)) begin
      strobes.rdSel = RD_MASK;
      strobes.wrMask = regWrEn;
    end else if (regAddr == ADDR_W'(OFS_PHY)) begin
      strobes.rdSel = RD_PHY;
    end else if (regAddr == ADDR_W'(OFS_STATUS)) begin
      strobes.rdSel = RD_STATUS;
      strobes.wrStatus = regWrEn;
    end else if (regAddr == ADDR_W'(OFS_QWORD1)) begin
      strobes.rdSel = RD_QWORD1;
      strobes.popReq = regWrEn;
    end else if (regAddr == ADDR_W'(OFS_QWORD2)) begin
      strobes.rdSel = RD_QWORD2;
      strobes.popReq = regWrEn;
    end
  end
endmodule

// File: rtl/intx_queue_datapath.sv
module intx_queue_datapath
  import intx_queue_pkg::*;
#(
  parameter int DEPTH = 8
) (
  input  logic          clk,
  input  logic          rstN,
  input  ctrl_strobes_t strobes,
  input  logic [31:0]   wrData,
  input  logic [1:0]    evtLane,
  input  logic          evtLevel,
  input  logic          linkUp,
  input  logic          msiRecv,
  output logic [31:0]   rdData,
  output logic          irqOut,
  output logic          bridgeEn
);
  localparam int PTR_W = (DEPTH > 2) ? $clog2(DEPTH) : 1;
  localparam int OCC_W = PTR_W + 1;

  function automatic logic [PTR_W-1:0] ptrInc(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  logic [2:0]       slotMem [DEPTH];
  logic [PTR_W-1:0] wrPtr, rdPtr, wrPtrNext, rdPtrNext;
  logic [31:0]      decodeReg, maskReg, decodeNext, setBits, clrBits;
  logic             overflowReg;
  logic             qEmpty, qFull, popOk, pushOk, ovfSet;
  logic [OCC_W-1:0] occupancy;
  logic [2:0]       headSlot;

  assign qEmpty = (wrPtr == rdPtr);
  assign qFull  = (ptrInc(wrPtr) == rdPtr);
  assign popOk  = strobes.popReq && !qEmpty;
  assign pushOk = strobes.pushReq && (!qFull || popOk);
  assign ovfSet = strobes.pushReq && !pushOk;

  assign wrPtrNext = pushOk ? ptrInc(wrPtr) : wrPtr;
  assign rdPtrNext = popOk  ? ptrInc(rdPtr) : rdPtr;
  assign occupancy = (wrPtr >= rdPtr) ? OCC_W'(wrPtr) - OCC_W'(rdPtr)
                                      : OCC_W'(DEPTH) + OCC_W'(wrPtr) - OCC_W'(rdPtr);

  always_comb begin
    setBits = '0;
    setBits[BIT_INTX] = pushOk;
    setBits[BIT_MSI]  = msiRecv;
    clrBits = strobes.wrDecode ? wrData : '0;
    decodeNext = (decodeReg | setBits) & ~clrBits;
    if (wrPtrNext != rdPtrNext) decodeNext[BIT_INTX] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr       <= '0;
      rdPtr       <= '0;
      decodeReg   <= '0;
      maskReg     <= '0;
      bridgeEn    <= 1'b0;
      overflowReg <= 1'b0;
    end else begin
      wrPtr     <= wrPtrNext;
      rdPtr     <= rdPtrNext;
      decodeReg <= decodeNext;
      if (strobes.wrMask) maskReg <= wrData;
      if (strobes.wrStatus) bridgeEn <= wrData[BIT_BRIDGE];
      if (ovfSet) overflowReg <= 1'b1;
      else if (strobes.wrStatus && wrData[BIT_OVERFLOW]) overflowReg <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (pushOk) slotMem[wrPtr] <= {evtLevel, evtLane};
  end

  assign headSlot = slotMem[rdPtr];
  assign irqOut   = |(decodeReg & maskReg);

  always_comb begin
    rdData = '0;
    case (strobes.rdSel)
      RD_DECODE: rdData = decodeReg;
      RD_MASK:   rdData = maskReg;
      RD_PHY:    rdData[BIT_LINK] = linkUp;
      RD_STATUS: begin
        rdData[BIT_BRIDGE]   = bridgeEn;
        rdData[BIT_NONEMPTY] = !qEmpty;
        rdData[BIT_OVERFLOW] = overflowReg;
      end
      RD_QWORD1: if (!qEmpty) rdData = {1'b1, 1'b0, headSlot[2], headSlot[1:0], 27'd0};
      default:   rdData = '0;
    endcase
  end

  // R3: a nonempty queue always shows INTx pending
  p_pend_nonempty_r3: assert property (@(posedge clk) disable iff (!rstN)
    (occupancy != '0) |-> decodeReg[BIT_INTX]);
  // R5: full queue, push without pop -> dropped, overflow set
  p_no_overflow_r5: assert property (@(posedge clk) disable iff (!rstN)
    (qFull && strobes.pushReq && !strobes.popReq) |=> (overflowReg && occupancy == $past(occupancy)));
  // R8: a lone pop on a nonempty queue removes exactly one entry
  p_pop_one_r8: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.popReq && !strobes.pushReq && !qEmpty) |=> (occupancy == $past(occupancy) - 1'b1));
  // R9: simultaneous push and pop keep the count and raise no overflow
  p_push_pop_r9: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.popReq && strobes.pushReq && !qEmpty) |=>
      (occupancy == $past(occupancy) && overflowReg == $past(overflowReg)));
  // R2: an accepted push with INTx unmasked raises the line next cycle
  p_irq_push_r2: assert property (@(posedge clk) disable iff (!rstN)
    (pushOk && maskReg[BIT_INTX] && !strobes.wrMask) |=> irqOut);
  // R5: occupancy never exceeds DEPTH-1
  p_occ_bound_r5: assert property (@(posedge clk) disable iff (!rstN)
    occupancy <= OCC_W'(DEPTH - 1));
endmodule

// File: rtl/intx_queue_regs.sv
module intx_queue_regs
  import intx_queue_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DEPTH  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [31:0]       regWrData,
  output logic [31:0]       regRdData,
  input  logic              evtValid,
  input  logic [1:0]        evtLane,
  input  logic              evtLevel,
  input  logic              linkUp,
  input  logic              msiRecv,
  output logic              irqOut,
  output logic              bridgeEn
);
  ctrl_strobes_t strobes;

  intx_queue_ctrl #(.ADDR_W(ADDR_W)) uCtrl (
    .regWrEn (regWrEn),
    .regAddr (regAddr),
    .evtValid(evtValid),
    .strobes (strobes)
  );

  intx_queue_datapath #(.DEPTH(DEPTH)) uDp (
    .clk     (clk),
    .rstN    (rstN),
    .strobes (strobes),
    .wrData  (regWrData),
    .evtLane (evtLane),
    .evtLevel(evtLevel),
    .linkUp  (linkUp),
    .msiRecv (msiRecv),
    .rdData  (regRdData),
    .irqOut  (irqOut),
    .bridgeEn(bridgeEn)
  );
endmodule

// File: tb/tb_intx_queue_regs.sv
module tb_intx_queue_regs;
  localparam int DEPTH = 8;
  localparam logic [7:0] A_DEC = 8'h4E, A_MASK = 8'h4F, A_PHY = 8'h51,
                         A_STAT = 8'h52, A_Q1 = 8'h56, A_Q2 = 8'h57;

  logic clk = 0, rstN = 0, regWrEn = 0, evtValid = 0, evtLevel = 0, linkUp = 0, msiRecv = 0;
  logic [7:0] regAddr = 0;
  logic [31:0] regWrData = 0, regRdData;
  logic [1:0] evtLane = 0;
  logic irqOut, bridgeEn;
  int errors = 0, checks = 0;
  logic [2:0] mq[$];
  logic [31:0] rv;

  always #5 clk = ~clk;

  intx_queue_regs #(.ADDR_W(8), .DEPTH(DEPTH)) dut (.*);

  function automatic logic [31:0] word1(input logic [2:0] e);
    return {1'b1, 1'b0, e[2], e[1:0], 27'd0};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    regAddr = a; #1; d = regRdData;
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    regAddr = a; regWrData = d; regWrEn = 1;
    @(negedge clk); regWrEn = 0;
  endtask

  task automatic push(input logic [1:0] lane, input logic lvl);
    evtLane = lane; evtLevel = lvl; evtValid = 1;
    @(negedge clk); evtValid = 0;
  endtask

  task automatic pushPop(input logic [1:0] lane, input logic lvl);
    evtLane = lane; evtLevel = lvl; evtValid = 1;
    regAddr = A_Q1; regWrEn = 1;
    @(negedge clk); evtValid = 0; regWrEn = 0;
  endtask

  task automatic drainCheck(input string req);
    while (mq.size() > 0) begin
      logic [2:0] e;
      e = mq.pop_front();
      rd(A_Q1, rv); chk({req, " head word1"}, rv, word1(e));
      rd(A_Q1, rv); chk("R7 read repeat", rv, word1(e));
      rd(A_Q2, rv); chk("R4 word2", rv, 32'd0);
      wr((mq.size() % 2) ? A_Q1 : A_Q2, 32'hDEAD_BEEF);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    // R1 reset state
    rd(A_DEC, rv);  chk("R1 decode", rv, 0);
    rd(A_MASK, rv); chk("R1 mask", rv, 0);
    rd(A_STAT, rv); chk("R1 status", rv, 0);
    rd(A_Q1, rv);   chk("R7 empty word1", rv, 0);
    chk("R1 irq", irqOut, 0);
    chk("R1 bridge", bridgeEn, 0);

    // R11 PHY word
    linkUp = 1; rd(A_PHY, rv); chk("R11 link up", rv, 32'h800);
    wr(A_PHY, 32'hFFFF_FFFF);
    linkUp = 0; rd(A_PHY, rv); chk("R11 link down after write", rv, 0);

    // R13 mask read/write
    wr(A_MASK, 32'hA5C3_0F96); rd(A_MASK, rv); chk("R13 mask", rv, 32'hA5C3_0F96);
    wr(A_MASK, 32'h0001_0000); chk("R2 irq low empty", irqOut, 0);

    // R5 fill sweep, last push overflows
    for (int i = 0; i < DEPTH; i++) begin
      logic [1:0] ln; logic lv;
      ln = 2'(i % 4); lv = 1'((i >> 1) & 1);
      push(ln, lv);
      if (mq.size() < DEPTH - 1) mq.push_back({lv, ln});
      if (i == 0) chk("R2 irq after push", irqOut, 1);
    end
    rd(A_STAT, rv); chk("R5 overflow and R10 nonempty", rv, 32'h000C_0000);
    rd(A_DEC, rv); chk("R3 pending set", rv, 32'h0001_0000);

    // R3 clear attempt while nonempty
    wr(A_DEC, 32'hFFFF_FFFF); rd(A_DEC, rv); chk("R3 bit16 held", rv, 32'h0001_0000);

    // R6 sticky overflow
    wr(A_STAT, 32'h0000_0000); rd(A_STAT, rv); chk("R6 kept on write 0", rv, 32'h000C_0000);
    wr(A_STAT, 32'h0008_0000); rd(A_STAT, rv); chk("R6 cleared", rv, 32'h0004_0000);

    // R9 push+pop while full
    void'(mq.pop_front()); mq.push_back({1'b1, 2'd3});
    pushPop(2'd3, 1'b1);
    rd(A_STAT, rv); chk("R9 no overflow at full", rv, 32'h0004_0000);
    push(2'd2, 1'b0);
    rd(A_STAT, rv); chk("R9 still full", rv, 32'h000C_0000);
    wr(A_STAT, 32'h0008_0000);

    drainCheck("R4 R8 R9");
    rd(A_Q1, rv); chk("R7 empty again", rv, 0);
    rd(A_STAT, rv); chk("R10 empty flag", rv, 0);
    rd(A_DEC, rv); chk("R3 pending stays until cleared", rv, 32'h0001_0000);
    wr(A_DEC, 32'h0001_0000); rd(A_DEC, rv); chk("R3 cleared when empty", rv, 0);
    chk("R2 irq low", irqOut, 0);

    // R8 empty pop ignored
    wr(A_Q2, 0); wr(A_Q1, 0);
    push(2'd1, 1'b1); rd(A_Q1, rv); chk("R8 empty pop ignored", rv, word1({1'b1, 2'd1}));
    // R9 push+pop with one entry
    pushPop(2'd2, 1'b0); rd(A_Q1, rv); chk("R9 single entry swap", rv, word1({1'b0, 2'd2}));
    wr(A_Q1, 0); rd(A_STAT, rv); chk("R9 empty after pop", rv, 0);
    wr(A_DEC, 32'hFFFF_FFFF);

    // R12 MSI pulse and R2 mask gating
    msiRecv = 1; @(negedge clk); msiRecv = 0;
    rd(A_DEC, rv); chk("R12 msi bit", rv, 32'h0002_0000);
    chk("R2 msi masked", irqOut, 0);
    wr(A_MASK, 32'h0002_0000); chk("R2 msi unmasked", irqOut, 1);
    wr(A_DEC, 32'h0002_0000); chk("R2 after clear", irqOut, 0);

    // R10 bridge enable
    wr(A_STAT, 32'h0000_0001); rd(A_STAT, rv); chk("R10 bridge set", rv, 1);
    chk("R10 bridge pin", bridgeEn, 1);
    wr(A_STAT, 32'h0000_0000); chk("R10 bridge clear", bridgeEn, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule